// File: doc/BRIEF.md
# Dual Timewheel Wakeup Timer

This block keeps time in a low-power domain using two counters that share one clock and advance only on tick enables. The slow wheel is a 13-bit free-running count that steps on a 1 kHz tick. It stops while the part hibernates or while the processor is halted for on-chip debugging. Software can clear it at any time. A chosen bit of this count raises a periodic interrupt flag each time that bit goes from 0 to 1.

The fast wheel is a 5-bit count that steps on a 100 kHz tick. It compares itself against a programmable terminal count, and on the tick where the two match it returns to zero. That same tick is its terminal event, which can set an interrupt flag. Both flags stay set until they are acknowledged. Each flag can also be allowed, one at a time, to drive a shared wake request that brings the system out of a low-power mode.

Firmware writes three locations through a small write port:

| Address | Effect |
|---|---|
| 0 | Configuration byte |
| 1 | Terminal count |
| 2 | Clear of the slow wheel |
| 3 | Ignored |

Top module: `dual_wheel_timer`

## Requirements
- R1: While reset is asserted, both counts, both flags and the wake request are 0. All enables, the tap select and the terminal count (active and pending) reset to 0.
- R2: On a cycle with `tickSlow` high and neither `hibernate` nor `dbgHalt` high, the slow count increases by one. After 8191 it wraps to 0; there is no terminal reload.
- R3: While `hibernate` or `dbgHalt` is high, the slow count holds its value even when `tickSlow` pulses.
- R4: A write to address 2 sets the slow count to 0 on the next edge, whatever the data. A clear wins over an advance in the same cycle, and that cycle produces no slow interrupt event.
- R5: On each `tickFast` cycle, the fast count returns to 0 if it equals the active terminal count, and otherwise increases by one. The period is therefore terminal count + 1 ticks, and a terminal count of 0 gives a terminal event on every tick.
- R6: A write to address 1 stores `wrData[4:0]` as the pending terminal count. The pending value becomes active only at the next reload.
- R7: The configuration byte at address 0 holds the enables and the tap select:

  | Bits | Meaning |
  |---|---|
  | `[0]` | Slow interrupt enable |
  | `[1]` | Fast interrupt enable |
  | `[2]` | Slow wake enable |
  | `[3]` | Fast wake enable |
  | `[7:4]` | Tap select |

  The slow flag sets when the slow interrupt enable is 1 and an advance makes slow-count bit k (k = tap select) go from 0 to 1. Tap values 13 to 15 never set the flag.
- R8: The fast flag sets on a terminal event when the fast interrupt enable (config bit 1) is 1.
- R9: Flags are sticky. A pulse on `intAck[0]` clears the slow flag and a pulse on `intAck[1]` clears the fast flag. If a set and an acknowledge happen in the same cycle, the set wins.
- R10: `wakeReq` equals (slow flag AND config bit 2) OR (fast flag AND config bit 3).
- R11: The fast wheel ignores `hibernate` and `dbgHalt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickSlow | input | 1 | Single-cycle 1 kHz advance pulse |
| tickFast | input | 1 | Single-cycle 100 kHz advance pulse |
| hibernate | input | 1 | Hibernate indication, freezes slow wheel |
| dbgHalt | input | 1 | Debug halt indication, freezes slow wheel |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| intAck | input | 2 | Write-one-to-clear acknowledge, bit 0 slow, bit 1 fast |
| slowCount | output | 13 | Slow wheel count |
| fastCount | output | 5 | Fast wheel count |
| slowFlag | output | 1 | Slow periodic interrupt flag |
| fastFlag | output | 1 | Fast terminal interrupt flag |
| wakeReq | output | 1 | Wake request |

## Verification
The assertions assume that the tick inputs are clean single-cycle pulses sampled on the clock. They also assume that an acknowledge pulse without a slow tick cannot meet a slow event in the same cycle, because a slow event needs a slow tick. The stimulus draws ticks, freeze levels, writes to all four addresses and acknowledges from a fixed-seed random source, so every combination of clear, advance and freeze occurs, including all of them at once. Directed runs add what random traffic rarely reaches: a full wrap of the slow wheel with the top tap, a terminal count of zero, and a terminal count change made partway through a period.

// File: rtl/tw_pkg.sv
package tw_pkg;
  parameter int SLOW_W = 13;
  parameter int FAST_W = 5;
  parameter int DATA_W = 8;
  parameter int SEL_W  = 4;
  parameter int ADDR_W = 2;

  localparam int TAP_N = 1 << SEL_W;

  // register addresses
  localparam logic [ADDR_W-1:0] ADDR_CFG = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_TC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLR = 2'd2;

  // configuration bit positions
  localparam int CFG_SLOW_IE = 0;
  localparam int CFG_FAST_IE = 1;
  localparam int CFG_SLOW_WE = 2;
  localparam int CFG_FAST_WE = 3;
  localparam int CFG_TAP_LO  = 4;

  typedef struct packed {
    logic              slowAdv;
    logic              slowClr;
    logic              fastAdv;
    logic [SEL_W-1:0]  tapSel;
    logic [FAST_W-1:0] tcPending;
  } strobe_t;

  typedef struct packed {
    logic slowEvt;
    logic fastEvt;
  } event_t;
endpackage

// File: rtl/tw_dpath.sv
module tw_dpath
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output event_t            evt,
  output logic [SLOW_W-1:0] slowCount,
  output logic [FAST_W-1:0] fastCount
);
  localparam logic [SLOW_W-1:0] SLOW_ONE = {{(SLOW_W-1){1'b0}}, 1'b1};
  localparam logic [FAST_W-1:0] FAST_ONE = {{(FAST_W-1){1'b0}}, 1'b1};

  logic [SLOW_W-1:0] slowNext;
  logic [TAP_N-1:0]  riseVec;
  logic [FAST_W-1:0] tcActive;
  logic              fastAtTc;

  assign slowNext = slowCount + SLOW_ONE;

  // rising transition of each selectable bit; taps beyond the counter stay 0
  genvar gi;
  generate
    for (gi = 0; gi < TAP_N; gi++) begin : g_tap
      if (gi < SLOW_W) begin : g_real
        assign riseVec[gi] = ~slowCount[gi] & slowNext[gi];
      end else begin : g_none
        assign riseVec[gi] = 1'b0;
      end
    end
  endgenerate

  assign fastAtTc    = (fastCount == tcActive);
  assign evt.slowEvt = strb.slowAdv & ~strb.slowClr & riseVec[strb.tapSel];
  assign evt.fastEvt = strb.fastAdv & fastAtTc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slowCount <= '0;
    end else if (strb.slowClr) begin
      slowCount <= '0;
    end else if (strb.slowAdv) begin
      slowCount <= slowNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastCount <= '0;
      tcActive  <= '0;
    end else if (strb.fastAdv) begin
      if (fastAtTc) begin
        fastCount <= '0;
        tcActive  <= strb.tcPending;
      end else begin
        fastCount <= fastCount + FAST_ONE;
      end
    end
  end
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSlow,
  input  logic              tickFast,
  input  logic              hibernate,
  input  logic              dbgHalt,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        intAck,
  input  event_t            evt,
  output strobe_t           strb,
  output logic              slowFlag,
  output logic              fastFlag,
  output logic              wakeReq
);
  logic              slowIntEn, fastIntEn, slowWakeEn, fastWakeEn;
  logic [SEL_W-1:0]  tapSel;
  logic [FAST_W-1:0] tcPending;
  logic              wrCfg, wrTc;

  assign wrCfg = wrEn && (wrAddr == ADDR_CFG);
  assign wrTc  = wrEn && (wrAddr == ADDR_TC);

  assign strb.slowAdv   = tickSlow & ~hibernate & ~dbgHalt;
  assign strb.slowClr   = wrEn && (wrAddr == ADDR_CLR);
  assign strb.fastAdv   = tickFast;
  assign strb.tapSel    = tapSel;
  assign strb.tcPending = tcPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slowIntEn  <= 1'b0;
      fastIntEn  <= 1'b0;
      slowWakeEn <= 1'b0;
      fastWakeEn <= 1'b0;
      tapSel     <= '0;
      tcPending  <= '0;
    end else begin
      if (wrCfg) begin
        slowIntEn  <= wrData[CFG_SLOW_IE];
        fastIntEn  <= wrData[CFG_FAST_IE];
        slowWakeEn <= wrData[CFG_SLOW_WE];
        fastWakeEn <= wrData[CFG_FAST_WE];
        tapSel     <= wrData[CFG_TAP_LO +: SEL_W];
      end
      if (wrTc) begin
        tcPending <= wrData[FAST_W-1:0];
      end
    end
  end

  // sticky flags, a new event beats an acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slowFlag <= 1'b0;
      fastFlag <= 1'b0;
    end else begin
      slowFlag <= (slowFlag & ~intAck[0]) | (evt.slowEvt & slowIntEn);
      fastFlag <= (fastFlag & ~intAck[1]) | (evt.fastEvt & fastIntEn);
    end
  end

  assign wakeReq = (slowFlag & slowWakeEn) | (fastFlag & fastWakeEn);
endmodule

// File: rtl/dual_wheel_timer.sv
module dual_wheel_timer
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSlow,
  input  logic              tickFast,
  input  logic              hibernate,
  input  logic              dbgHalt,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        intAck,
  output logic [SLOW_W-1:0] slowCount,
  output logic [FAST_W-1:0] fastCount,
  output logic              slowFlag,
  output logic              fastFlag,
  output logic              wakeReq
);
  strobe_t strb;
  event_t  evt;

  tw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickSlow(tickSlow), .tickFast(tickFast),
    .hibernate(hibernate), .dbgHalt(dbgHalt), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .intAck(intAck), .evt(evt), .strb(strb),
    .slowFlag(slowFlag), .fastFlag(fastFlag), .wakeReq(wakeReq)
  );

  tw_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .evt(evt),
    .slowCount(slowCount), .fastCount(fastCount)
  );
endmodule

// File: rtl/tw_checker.sv
module tw_checker
  import tw_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tickSlow,
  input logic              tickFast,
  input logic              hibernate,
  input logic              dbgHalt,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [1:0]        intAck,
  input logic [SLOW_W-1:0] slowCount,
  input logic [FAST_W-1:0] fastCount,
  input logic              slowFlag,
  input logic              fastFlag,
  input logic              wakeReq
);
  logic clrHit;
  assign clrHit = wrEn && (wrAddr == ADDR_CLR);

  assert_slow_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickSlow && !hibernate && !dbgHalt && !clrHit
    |=> slowCount == SLOW_W'($past(slowCount) + 1'b1));

  assert_slow_freeze_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hibernate || dbgHalt) && !clrHit |=> $stable(slowCount));

  assert_slow_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    clrHit |=> slowCount == '0);

  assert_fast_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !tickFast |=> $stable(fastCount));

  assert_slow_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    slowFlag && !intAck[0] |=> slowFlag);

  assert_fast_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    fastFlag && !intAck[1] |=> fastFlag);

  assert_slow_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    intAck[0] && !tickSlow |=> !slowFlag);

  assert_wake_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (slowFlag || fastFlag));
endmodule

bind dual_wheel_timer tw_checker u_chk (
  .clk(clk), .rstN(rstN), .tickSlow(tickSlow), .tickFast(tickFast),
  .hibernate(hibernate), .dbgHalt(dbgHalt), .wrEn(wrEn), .wrAddr(wrAddr),
  .intAck(intAck), .slowCount(slowCount), .fastCount(fastCount),
  .slowFlag(slowFlag), .fastFlag(fastFlag), .wakeReq(wakeReq)
);

// File: tb/sim_dual_wheel_timer.sv
module sim_dual_wheel_timer;
  logic        clk = 1'b0;
  logic        rstN, tickSlow, tickFast, hibernate, dbgHalt, wrEn;
  logic [1:0]  wrAddr, intAck;
  logic [7:0]  wrData;
  logic [12:0] slowCount;
  logic [4:0]  fastCount;
  logic        slowFlag, fastFlag, wakeReq;

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  logic [12:0] mSlow;
  logic [4:0]  mFast, mTcAct, mTcPend;
  logic [7:0]  mCfg;
  logic        mSF, mFF;

  always #4 clk = ~clk;

  dual_wheel_timer u0 (
    .clk(clk), .rstN(rstN), .tickSlow(tickSlow), .tickFast(tickFast),
    .hibernate(hibernate), .dbgHalt(dbgHalt), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .intAck(intAck), .slowCount(slowCount),
    .fastCount(fastCount), .slowFlag(slowFlag), .fastFlag(fastFlag),
    .wakeReq(wakeReq)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expWake();
    return (mSF && mCfg[2]) || (mFF && mCfg[3]);
  endfunction

  task automatic compareAll();
    check("R2/R3/R4 slowCount", int'(slowCount), int'(mSlow));
    check("R5/R6/R11 fastCount", int'(fastCount), int'(mFast));
    check("R7/R9 slowFlag", int'(slowFlag), int'(mSF));
    check("R8/R9 fastFlag", int'(fastFlag), int'(mFF));
    check("R10 wakeReq", int'(wakeReq), int'(expWake()));
  endtask

  // advance the model by one clock edge using the current inputs
  task automatic modelAdvance();
    logic adv, clr, sEv, fEv;
    logic [12:0] nxt;
    int tap;
    adv = tickSlow && !hibernate && !dbgHalt;
    clr = wrEn && (wrAddr == 2'd2);
    tap = int'(mCfg[7:4]);
    nxt = mSlow + 13'd1;
    sEv = 1'b0;
    if (adv && !clr && tap < 13) sEv = !mSlow[tap] && nxt[tap];
    fEv = tickFast && (mFast == mTcAct);
    mSF = (mSF && !intAck[0]) || (sEv && mCfg[0]);
    mFF = (mFF && !intAck[1]) || (fEv && mCfg[1]);
    if (clr) mSlow = '0;
    else if (adv) mSlow = nxt;
    if (tickFast) begin
      if (mFast == mTcAct) begin
        mFast = '0;
        mTcAct = mTcPend;
      end else mFast = mFast + 5'd1;
    end
    if (wrEn && wrAddr == 2'd0) mCfg = wrData;
    if (wrEn && wrAddr == 2'd1) mTcPend = wrData[4:0];
  endtask

  task automatic step();
    modelAdvance();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idleInputs();
    tickSlow = 0; tickFast = 0; hibernate = 0; dbgHalt = 0;
    wrEn = 0; wrAddr = 0; wrData = 0; intAck = 0;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    idleInputs();
    wrEn = 1; wrAddr = a; wrData = d;
    step();
    idleInputs();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idleInputs();
    rstN = 0;
    mSlow = 0; mFast = 0; mTcAct = 0; mTcPend = 0; mCfg = 0; mSF = 0; mFF = 0;
    repeat (3) @(negedge clk);
    // R1 reset state, with ticks applied during reset
    tickSlow = 1; tickFast = 1;
    @(negedge clk);
    check("R1 slowCount", int'(slowCount), 0);
    check("R1 fastCount", int'(fastCount), 0);
    check("R1 flags", int'({slowFlag, fastFlag, wakeReq}), 0);
    idleInputs();
    rstN = 1;

    // R5: terminal count 0 gives an event each tick; enable fast irq+wake
    writeReg(2'd0, 8'h0A);
    for (int i = 0; i < 6; i++) begin tickFast = 1; step(); end
    tickFast = 0;
    // R9: acknowledge clears the fast flag
    intAck = 2'b10; step(); intAck = 0; step();

    // R6: new terminal count waits for the next reload
    writeReg(2'd1, 8'd3);
    for (int i = 0; i < 12; i++) begin tickFast = 1; step(); end
    writeReg(2'd1, 8'd1);
    for (int i = 0; i < 10; i++) begin tickFast = (i % 2 == 0); step(); end

    // R3 / R11: freeze slow wheel, fast keeps running
    hibernate = 1;
    for (int i = 0; i < 5; i++) begin tickSlow = 1; tickFast = 1; step(); end
    hibernate = 0; dbgHalt = 1;
    for (int i = 0; i < 5; i++) begin tickSlow = 1; tickFast = 1; step(); end
    idleInputs();

    // R4: clear coinciding with an advance
    tickSlow = 1; step(); step();
    tickSlow = 1; wrEn = 1; wrAddr = 2'd2; wrData = 8'hFF; step();
    idleInputs();

    // R2 / R7: full wrap with top tap, slow irq and wake enabled
    writeReg(2'd0, 8'hC5);
    for (int i = 0; i < 8200; i++) begin tickSlow = 1; step(); end
    // R9: set and ack in the same cycle, set wins (tap 0 rises on even->odd)
    writeReg(2'd0, 8'h05);
    tickSlow = 1; intAck = 2'b01; step();
    tickSlow = 1; intAck = 2'b01; step();
    idleInputs(); step();
    // tap beyond counter never fires
    writeReg(2'd0, 8'hF5);
    intAck = 2'b11; step(); intAck = 0;
    for (int i = 0; i < 40; i++) begin tickSlow = 1; step(); end
    idleInputs();

    // constrained random traffic
    for (int i = 0; i < 25000; i++) begin
      tickSlow  = ($urandom % 3) == 0;
      tickFast  = ($urandom % 2) == 0;
      hibernate = ($urandom % 10) == 0;
      dbgHalt   = ($urandom % 10) == 0;
      wrEn      = ($urandom % 14) == 0;
      wrAddr    = 2'($urandom % 4);
      wrData    = 8'($urandom);
      if (wrEn && wrAddr == 2'd0 && ($urandom % 2) == 0) wrData[7:4] = 4'($urandom % 3);
      intAck    = (($urandom % 6) == 0) ? 2'($urandom % 4) : 2'b00;
      step();
    end
    idleInputs();
    step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule